// File: doc/BRIEF.md
# I2C Configuration Register Bank

This block is the configuration endpoint of a serial video link device. An external controller reaches it over a two-wire I2C-compatible bus. Through an 8-bit register file it sets the pixel sampling edge, the fallback to a local oscillator when the pixel clock is missing, and eight general-purpose output levels. It also reads back whether a valid pixel clock is present. The bus lines are presented as separate input, output and output-enable signals. Both bus lines are oversampled in the block's own clock domain, so SCL must stay well below the system clock rate.

The device answers to one 7-bit slave address. By default that address comes from a 3-bit strap code. Register 0 can replace it with a value written over the bus. Two self-clearing command bits act from inside the register file. One returns the control registers to their defaults and leaves the address register as it is. The other sends a one-clock pulse to the datapath and leaves every register unchanged. The power-down input returns every register, the address register included, to its default.

Top module: `cfgbank_i2c_regs`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal the active slave address. For any other address it leaves SDA released for the whole transaction and no register changes.
- R2: When bit 0 of register 0x00 is 0, the active address comes from the strap code: 0→0x58, 1→0x59, 2→0x5A, 3→0x5B, 4→0x5C, 5→0x5E, and 6 or 7→0x58. When that bit is 1, the address is bits 7:1 of register 0x00. The register defaults to 0xB0, and dev_addr_o always shows the active address.
- R3: A write transaction is an address byte with bit 0 = 0, then a register-pointer byte, then data bytes. Each data byte is stored at the pointer, after which the pointer advances by one. The new value reaches the outputs on the fourth clock after the SCL falling edge that ends the eighth bit of that data byte.
- R4: A read transaction is an address byte with bit 0 = 1. Data is sent most significant bit first, starting at the current pointer. The pointer advances after each byte. Reading continues while the controller acknowledges and stops after a not-acknowledge.
- R5: Register 0x03 holds two bits, both defaulting to 1. Bit 0 drives edge_rise_o (1 means rising edge) and bit 1 drives osc_fallback_o. Its other bits read as 0.
- R6: Register 0x13 defaults to 0x00 and drives gpo_o bit for bit.
- R7: Writing register 0x01 with bit 1 set returns registers 0x03 and 0x13 to their defaults two clocks after the write strobe. Register 0x00 is kept. Register 0x01 always reads 0x00.
- R8: Writing register 0x01 with bit 0 set raises logic_rst_o for exactly one clock, in the same cycle that a data write would reach the outputs. No register value changes.
- R9: Bit 2 of register 0x0C reads pclk_valid_i at read time, and writes to that register are ignored. Addresses other than 0x00, 0x01, 0x03, 0x0C and 0x13 read 0x00 and ignore writes.
- R10: After rst_n low, or one clock after pwr_down is high, every register holds its default, register 0x00 included, and the bus logic is idle.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_o | output | 1 | Data line output value (always 0, open-drain) |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| strap_code | input | 3 | Decoded address strap |
| pwr_down | input | 1 | Synchronous return of all registers to defaults |
| pclk_valid_i | input | 1 | Pixel clock detected status |
| dev_addr_o | output | 7 | Active slave address |
| edge_rise_o | output | 1 | Pixel sampling edge select, 1 = rising |
| osc_fallback_o | output | 1 | Enables the local oscillator when the pixel clock is absent |
| gpo_o | output | 8 | General-purpose output levels |
| logic_rst_o | output | 1 | One-clock datapath reset pulse |

## Verification
Each bus line passes through two synchronizer flops and one edge flop, and each transfer is then registered once. Written values therefore appear on the fourth clock after the SCL fall that ends a data byte. A datapath reset pulse appears in that same cycle, and a restore of defaults appears one clock later. Power-down acts on the first clock at which it is seen. The bench keeps a queue of pending model updates keyed to those exact cycles and compares every output on every clock, 1 ns after the edge. Read data and acknowledge bits are sampled in the middle of the SCL high phase, several clocks after the block has updated SDA.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int REG_W = 8;
  localparam int SADDR_W = 7;

  localparam logic [REG_W-1:0] A_IDENT   = 8'h00;
  localparam logic [REG_W-1:0] A_SOFTRST = 8'h01;
  localparam logic [REG_W-1:0] A_CLKCFG  = 8'h03;
  localparam logic [REG_W-1:0] A_STATUS  = 8'h0C;
  localparam logic [REG_W-1:0] A_GPOUT   = 8'h13;

  localparam logic [REG_W-1:0] IDENT_DEF  = 8'hB0;
  localparam logic [1:0]       CLKCFG_DEF = 2'b11;
  localparam logic [REG_W-1:0] GPOUT_DEF  = 8'h00;

  typedef enum logic [3:0] {
    BS_IDLE, BS_ADDR, BS_AACK, BS_PTR, BS_PACK,
    BS_WDAT, BS_WACK, BS_RDAT, BS_RACK
  } bus_st_e;

  function automatic logic [SADDR_W-1:0] strap_to_addr(input logic [2:0] code);
    case (code)
      3'd1:    return 7'h59;
      3'd2:    return 7'h5A;
      3'd3:    return 7'h5B;
      3'd4:    return 7'h5C;
      3'd5:    return 7'h5E;
      default: return 7'h58;
    endcase
  endfunction

endpackage

// File: rtl/cfgbank_sync.sv
module cfgbank_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {(STAGES+1){RST_VAL}};
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign level = sh_q[STAGES-1];
  assign rise  = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall  = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/cfgbank_bus.sv
module cfgbank_bus
  import cfgbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_down,
  input  logic               scl_lvl,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               sda_lvl,
  input  logic               sda_rise,
  input  logic               sda_fall,
  input  logic [SADDR_W-1:0] dev_addr,
  input  logic [REG_W-1:0]   rd_data,
  output logic [REG_W-1:0]   ptr,
  output logic               wr_en,
  output logic [REG_W-1:0]   wr_addr,
  output logic [REG_W-1:0]   wr_data,
  output logic               sda_drive
);
  bus_st_e          st_q, st_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [REG_W-1:0] sh_q, sh_d, tx_q, tx_d, ptr_q, ptr_d, wa_q, wa_d, wd_q, wd_d;
  logic             rw_q, rw_d, drv_q, drv_d, wr_q, wr_d, mack_q, mack_d;
  logic             start_det, stop_det;

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; tx_d = tx_q; ptr_d = ptr_q;
    wa_d = wa_q; wd_d = wd_q; rw_d = rw_q; drv_d = drv_q; mack_d = mack_q;
    wr_d = 1'b0;
    if (pwr_down || stop_det) begin
      st_d = BS_IDLE; drv_d = 1'b0;
    end else if (start_det) begin
      st_d = BS_ADDR; cnt_d = '0; drv_d = 1'b0;
    end else begin
      if (scl_rise && (st_q == BS_ADDR || st_q == BS_PTR || st_q == BS_WDAT)) begin
        sh_d  = {sh_q[REG_W-2:0], sda_lvl};
        cnt_d = cnt_q + 4'd1;
      end
      if (scl_rise && st_q == BS_RACK) mack_d = ~sda_lvl;
      if (scl_fall) begin
        case (st_q)
          BS_ADDR: if (cnt_q == 4'd8) begin
            if (sh_q[REG_W-1:1] == dev_addr) begin
              st_d = BS_AACK; drv_d = 1'b1; rw_d = sh_q[0];
            end else begin
              st_d = BS_IDLE;
            end
          end
          BS_AACK: begin
            cnt_d = '0;
            if (rw_q) begin
              st_d = BS_RDAT; tx_d = rd_data; drv_d = ~rd_data[REG_W-1];
            end else begin
              st_d = BS_PTR; drv_d = 1'b0;
            end
          end
          BS_PTR: if (cnt_q == 4'd8) begin
            ptr_d = sh_q; st_d = BS_PACK; drv_d = 1'b1;
          end
          BS_PACK, BS_WACK: begin
            st_d = BS_WDAT; drv_d = 1'b0; cnt_d = '0;
          end
          BS_WDAT: if (cnt_q == 4'd8) begin
            wr_d = 1'b1; wa_d = ptr_q; wd_d = sh_q;
            ptr_d = ptr_q + 8'd1; st_d = BS_WACK; drv_d = 1'b1;
          end
          BS_RDAT: begin
            if (cnt_q == 4'd7) begin
              drv_d = 1'b0; ptr_d = ptr_q + 8'd1; st_d = BS_RACK;
            end else begin
              tx_d  = {tx_q[REG_W-2:0], 1'b0};
              drv_d = ~tx_q[REG_W-2];
              cnt_d = cnt_q + 4'd1;
            end
          end
          BS_RACK: begin
            if (mack_q) begin
              st_d = BS_RDAT; tx_d = rd_data; drv_d = ~rd_data[REG_W-1]; cnt_d = '0;
            end else begin
              st_d = BS_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BS_IDLE; cnt_q <= '0; sh_q <= '0; tx_q <= '0; ptr_q <= '0;
      wa_q <= '0; wd_q <= '0; rw_q <= 1'b0; drv_q <= 1'b0; wr_q <= 1'b0; mack_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; tx_q <= tx_d; ptr_q <= ptr_d;
      wa_q <= wa_d; wd_q <= wd_d; rw_q <= rw_d; drv_q <= drv_d; wr_q <= wr_d; mack_q <= mack_d;
    end
  end

  assign ptr       = ptr_q;
  assign wr_en     = wr_q;
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;
  assign sda_drive = drv_q;
endmodule

// File: rtl/cfgbank_regs.sv
module cfgbank_regs
  import cfgbank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_down,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [REG_W-1:0]   rd_addr,
  input  logic               pclk_valid,
  input  logic [2:0]         strap_code,
  output logic [REG_W-1:0]   rd_data,
  output logic [SADDR_W-1:0] dev_addr,
  output logic               edge_rise,
  output logic               osc_fallback,
  output logic [REG_W-1:0]   gpo,
  output logic               logic_rst
);
  logic [REG_W-1:0] id_q, id_d, gpo_q, gpo_d;
  logic [1:0]       clk_q, clk_d, sc_q, sc_d;

  always_comb begin
    id_d = id_q; clk_d = clk_q; gpo_d = gpo_q; sc_d = 2'b00;
    if (pwr_down) begin
      id_d = IDENT_DEF; clk_d = CLKCFG_DEF; gpo_d = GPOUT_DEF;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_IDENT:   id_d  = wr_data;
          A_SOFTRST: sc_d  = wr_data[1:0];
          A_CLKCFG:  clk_d = wr_data[1:0];
          A_GPOUT:   gpo_d = wr_data;
          default: ;
        endcase
      end
      if (sc_q[1]) begin
        clk_d = CLKCFG_DEF; gpo_d = GPOUT_DEF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= IDENT_DEF; clk_q <= CLKCFG_DEF; gpo_q <= GPOUT_DEF; sc_q <= 2'b00;
    end else begin
      id_q <= id_d; clk_q <= clk_d; gpo_q <= gpo_d; sc_q <= sc_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_IDENT:  rd_data = id_q;
      A_CLKCFG: rd_data = {6'b0, clk_q};
      A_STATUS: rd_data = {5'b0, pclk_valid, 2'b0};
      A_GPOUT:  rd_data = gpo_q;
      default:  rd_data = '0;
    endcase
  end

  assign dev_addr     = id_q[0] ? id_q[REG_W-1:1] : strap_to_addr(strap_code);
  assign edge_rise    = clk_q[0];
  assign osc_fallback = clk_q[1];
  assign gpo          = gpo_q;
  assign logic_rst    = sc_q[0];
endmodule

// File: rtl/cfgbank_i2c_regs.sv
module cfgbank_i2c_regs
  import cfgbank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_o,
  output logic               sda_oe,
  input  logic [2:0]         strap_code,
  input  logic               pwr_down,
  input  logic               pclk_valid_i,
  output logic [SADDR_W-1:0] dev_addr_o,
  output logic               edge_rise_o,
  output logic               osc_fallback_o,
  output logic [REG_W-1:0]   gpo_o,
  output logic               logic_rst_o
);
  logic [1:0]         rst_pipe_q;
  logic               rst_s;
  logic               scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
  logic [REG_W-1:0]   ptr, wr_addr, wr_data, rd_data;
  logic               wr_en, sda_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  cfgbank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst_n(rst_s), .din(scl_i),
    .level(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  cfgbank_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst_n(rst_s), .din(sda_i),
    .level(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  cfgbank_bus u_bus (
    .clk(clk), .rst_n(rst_s), .pwr_down(pwr_down),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .dev_addr(dev_addr_o), .rd_data(rd_data), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_drive(sda_drive));

  cfgbank_regs u_regs (
    .clk(clk), .rst_n(rst_s), .pwr_down(pwr_down),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(ptr),
    .pclk_valid(pclk_valid_i), .strap_code(strap_code), .rd_data(rd_data),
    .dev_addr(dev_addr_o), .edge_rise(edge_rise_o), .osc_fallback(osc_fallback_o),
    .gpo(gpo_o), .logic_rst(logic_rst_o));

  assign sda_o  = 1'b0;
  assign sda_oe = sda_drive;
endmodule

// File: rtl/cfgbank_i2c_regs_chk.sv
module cfgbank_i2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_down,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       logic_rst_o,
  input logic       edge_rise_o,
  input logic       osc_fallback_o,
  input logic [7:0] gpo_o
);
  assert_gpo_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (gpo_o == 8'h00));

  assert_clkcfg_default_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (edge_rise_o && osc_fallback_o));

  assert_lrst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    logic_rst_o |=> !logic_rst_o);

  assert_lrst_keeps_gpo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(logic_rst_o) |-> $stable(gpo_o));

  assert_sda_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));
endmodule

bind cfgbank_i2c_regs cfgbank_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .scl_i(scl_i), .sda_oe(sda_oe),
  .logic_rst_o(logic_rst_o), .edge_rise_o(edge_rise_o),
  .osc_fallback_o(osc_fallback_o), .gpo_o(gpo_o));

// File: tb/cfgbank_i2c_regs_tb.sv
module cfgbank_i2c_regs_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, m_scl, m_sda, pwr_down, pclk_valid;
  logic [2:0] strap;
  logic       sda_o, sda_oe, edge_rise, osc_fb, lrst;
  logic [7:0] gpo;
  logic [6:0] dev_addr;
  logic       sda_line;

  assign sda_line = m_sda & ~(sda_oe & ~sda_o);

  cfgbank_i2c_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .strap_code(strap), .pwr_down(pwr_down),
    .pclk_valid_i(pclk_valid), .dev_addr_o(dev_addr), .edge_rise_o(edge_rise),
    .osc_fallback_o(osc_fb), .gpo_o(gpo), .logic_rst_o(lrst));

  int cyc = 0, n_tests = 0, n_fail = 0;
  bit mon_on = 0, done = 0;
  logic [7:0] m_r0 = 8'hB0, m_gpo = 8'h00;
  logic [1:0] m_r3 = 2'b11;
  int m_lrst_cyc = -1;
  int ev_due[$], ev_kind[$], ev_a[$], ev_d[$];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [6:0] strap_addr(input logic [2:0] s);
    case (s)
      3'd1: return 7'h59;  3'd2: return 7'h5A;  3'd3: return 7'h5B;
      3'd4: return 7'h5C;  3'd5: return 7'h5E;  default: return 7'h58;
    endcase
  endfunction

  function automatic logic [6:0] exp_addr();
    return m_r0[0] ? m_r0[7:1] : strap_addr(strap);
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    case (a)
      8'h00: return m_r0;
      8'h03: return {6'b0, m_r3};
      8'h0C: return {5'b0, pclk_valid, 2'b0};
      8'h13: return m_gpo;
      default: return 8'h00;
    endcase
  endfunction

  // kind 0 = data write, 1 = soft default, 2 = power-down
  task automatic apply_ev(input int kind, input int a, input int d);
    if (kind == 2) begin
      m_r0 = 8'hB0; m_r3 = 2'b11; m_gpo = 8'h00;
    end else if (kind == 1) begin
      m_r3 = 2'b11; m_gpo = 8'h00;
    end else begin
      case (a)
        8'h00: m_r0 = 8'(d);
        8'h01: begin
          if (d[0]) m_lrst_cyc = cyc;
          if (d[1]) begin ev_due.push_back(cyc + 1); ev_kind.push_back(1); ev_a.push_back(0); ev_d.push_back(0); end
        end
        8'h03: m_r3 = 2'(d);
        8'h13: m_gpo = 8'(d);
        default: ;
      endcase
    end
  endtask

  task automatic push_ev(input int due, input int kind, input int a, input int d);
    ev_due.push_back(due); ev_kind.push_back(kind); ev_a.push_back(a); ev_d.push_back(d);
  endtask

  // per-clock reference comparison
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (ev_due.size() > 0 && ev_due[0] == cyc) begin
        apply_ev(ev_kind[0], ev_a[0], ev_d[0]);
        void'(ev_due.pop_front()); void'(ev_kind.pop_front());
        void'(ev_a.pop_front()); void'(ev_d.pop_front());
      end
      if (mon_on) begin
        chk("R5", "edge_rise_o", edge_rise, m_r3[0]);
        chk("R5", "osc_fallback_o", osc_fb, m_r3[1]);
        chk("R6", "gpo_o", gpo, m_gpo);
        chk("R2", "dev_addr_o", dev_addr, exp_addr());
        chk("R8", "logic_rst_o", lrst, (cyc == m_lrst_cyc));
      end
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(H); m_scl = 1'b1; w(H); m_sda = 1'b0; w(H); m_scl = 1'b0; w(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(H); m_scl = 1'b1; w(H); m_sda = 1'b1; w(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input int reg_a, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(H); m_scl = 1'b1; w(H); m_scl = 1'b0;
      if (i == 0 && reg_a >= 0) push_ev(cyc + 4, 0, reg_a, int'(b));
      w(2);
    end
    m_sda = 1'b1; w(H); m_scl = 1'b1; w(H/2); ack = !sda_line; w(H/2); m_scl = 1'b0; w(2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H); m_scl = 1'b1; w(H/2); b[i] = sda_line; w(H/2); m_scl = 1'b0; w(2);
    end
    m_sda = !give_ack; w(H); m_scl = 1'b1; w(H); m_scl = 1'b0; w(2); m_sda = 1'b1;
  endtask

  task automatic reg_wr(input string req, input logic [6:0] sa, input logic [7:0] ptr,
                        input logic [7:0] dat [4], input int n);
    bit ak;
    bit live;
    live = (sa == exp_addr());
    bus_start();
    send_byte({sa, 1'b0}, -1, ak);
    chk(live ? req : "R1", "address ack (write)", ak, live);
    send_byte(ptr, -1, ak);
    if (live) chk(req, "pointer ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(dat[i], live ? ((int'(ptr) + i) & 255) : -1, ak);
      if (live) chk(req, "data ack", ak, 1);
    end
    bus_stop();
    w(H);
  endtask

  task automatic reg_rd(input string req, input logic [6:0] sa, input logic [7:0] ptr, input int n);
    bit ak;
    logic [7:0] b;
    bus_start();
    send_byte({sa, 1'b0}, -1, ak);
    chk(req, "address ack (pointer set)", ak, 1);
    send_byte(ptr, -1, ak);
    bus_start();
    send_byte({sa, 1'b1}, -1, ak);
    chk(req, "address ack (read)", ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(req, $sformatf("read data @%0h", (int'(ptr) + i) & 255), b, exp_read((int'(ptr) + i) & 255));
    end
    bus_stop();
    w(H);
  endtask

  task automatic power_down();
    pwr_down = 1'b1; push_ev(cyc + 1, 2, 0, 0); w(1); pwr_down = 1'b0; w(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] d [4];
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; pwr_down = 1'b0; pclk_valid = 1'b0; strap = 3'd0;
    w(5); rst_n = 1'b1; w(10);
    mon_on = 1;
    // R10: reset state
    chk("R10", "reset gpo_o", gpo, 8'h00);
    chk("R10", "reset edge_rise_o", edge_rise, 1'b1);
    chk("R10", "reset osc_fallback_o", osc_fb, 1'b1);
    chk("R2", "reset dev_addr_o", dev_addr, 7'h58);
    chk("R11", "reset sda_oe", sda_oe, 1'b0);

    // R3, R6: single write to GPO, then R4 readback
    d = '{8'hA5, 0, 0, 0};
    reg_wr("R3", 7'h58, 8'h13, d, 1);
    reg_rd("R4", 7'h58, 8'h13, 1);

    // R5: clock config, upper bits read 0
    d = '{8'hFE, 0, 0, 0};
    reg_wr("R5", 7'h58, 8'h03, d, 1);
    reg_rd("R5", 7'h58, 8'h03, 1);

    // R3 auto-increment across an undefined address (R9)
    d = '{8'h77, 8'h3C, 0, 0};
    reg_wr("R9", 7'h58, 8'h12, d, 2);
    reg_rd("R9", 7'h58, 8'h12, 2);

    // R4: multi-byte read from 0x00
    reg_rd("R4", 7'h58, 8'h00, 4);

    // R1: foreign address is not acknowledged and writes are ignored
    d = '{8'hFF, 0, 0, 0};
    reg_wr("R1", 7'h33, 8'h13, d, 1);
    chk("R1", "gpo after foreign write", gpo, 8'h3C);

    // R2: strap decoding
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s); w(3);
      chk("R2", $sformatf("strap %0d address", s), dev_addr, strap_addr(3'(s)));
    end
    strap = 3'd5; w(3);
    d = '{8'h11, 0, 0, 0};
    reg_wr("R1", 7'h58, 8'h13, d, 1);
    reg_wr("R2", 7'h5E, 8'h13, d, 1);
    chk("R2", "gpo via strap 5 address", gpo, 8'h11);

    // R2: register override of the address
    d = '{8'h4B, 0, 0, 0};
    reg_wr("R2", 7'h5E, 8'h00, d, 1);
    chk("R2", "override address", dev_addr, 7'h25);
    d = '{8'h96, 0, 0, 0};
    reg_wr("R2", 7'h25, 8'h13, d, 1);
    reg_rd("R2", 7'h25, 8'h00, 1);

    // R9: status bit is read-only and follows the input
    pclk_valid = 1'b1;
    reg_rd("R9", 7'h25, 8'h0C, 1);
    d = '{8'h00, 0, 0, 0};
    reg_wr("R9", 7'h25, 8'h0C, d, 1);
    reg_rd("R9", 7'h25, 8'h0C, 1);
    pclk_valid = 1'b0;
    reg_rd("R9", 7'h25, 8'h0C, 1);

    // R8: datapath reset pulse, registers untouched
    d = '{8'h01, 0, 0, 0};
    reg_wr("R8", 7'h25, 8'h01, d, 1);
    chk("R8", "gpo kept after datapath reset", gpo, 8'h96);
    reg_rd("R7", 7'h25, 8'h01, 1);

    // R7: restore defaults, address register kept
    d = '{8'h02, 0, 0, 0};
    reg_wr("R7", 7'h25, 8'h01, d, 1);
    chk("R7", "gpo default after restore", gpo, 8'h00);
    chk("R7", "edge default after restore", edge_rise, 1'b1);
    chk("R7", "address kept after restore", dev_addr, 7'h25);
    reg_rd("R7", 7'h25, 8'h00, 1);

    // R10: power-down returns everything, address register included
    d = '{8'h5A, 8'h00, 0, 0};
    reg_wr("R10", 7'h25, 8'h13, d, 1);
    d = '{8'h01, 0, 0, 0};
    reg_wr("R10", 7'h25, 8'h03, d, 1);
    power_down();
    chk("R10", "gpo after power-down", gpo, 8'h00);
    chk("R10", "osc after power-down", osc_fb, 1'b1);
    chk("R10", "address after power-down", dev_addr, 7'h5E);
    reg_rd("R10", 7'h5E, 8'h00, 1);

    w(20);
    finish_run();
  end
endmodule